// File: doc/BRIEF.md
# Fan Tachometer Capture Channel

One measurement channel of a fan-speed timer. A down-counter starts at its all-ones value and steps down by one on each prescaled tick. The first qualifying edge on the selected tachometer pin freezes the running count into a capture register. A fan gives two pulses per revolution, so software can turn the distance between the start value and the captured value into half a revolution's period. If the counter is already at zero when the next tick arrives, the measurement ends with an underflow and nothing is captured. An optional compare against a programmable threshold can end the measurement sooner.

Each measurement ends in exactly one of three outcomes: capture, underflow or compare hit. Each outcome gives a one-cycle strobe. The count then stays at its final value until the next tick, which reloads the all-ones value and starts a new measurement. Register decoding and interrupt merging are left to the surrounding logic.

Top module: `tach_capture_chan`

## Requirements
- R1: Reset drives `count_o` to all ones and `capture_o` to zero, and holds all three strobes low.
- R2: The channel runs only while `mode_en_i`, `chan_en_i` and `clk_sel_i` are all 1. Otherwise `count_o` sits at all ones, pin edges are dropped and no strobe is raised.
- R3: With prescale value P, the count drops by one every P+1 clock cycles. The first decrement lands on the (P+1)th rising edge after the channel starts running.
- R4: `tach_sel_i`=0 selects `tach_a_i` and 1 selects `tach_b_i`. `edge_pol_i`=1 qualifies rising edges and 0 qualifies falling edges. The unselected pin and the opposite edge have no effect.
- R5: A qualifying pin change made between two rising clock edges raises `capture_evt_o` after the third following rising edge. `capture_o` then holds the count that was present after the second following edge, and `count_o` holds that same value during the strobe.
- R6: A tick that arrives while the count is zero raises `underflow_evt_o`. The count stays at zero and `capture_o` is unchanged.
- R7: Compare configuration bit 3 hits on a tick while the count is all ones. Bit 2 hits on a tick while the count equals the threshold. Bit 1 hits on a tick while the count equals threshold minus one, but only for a nonzero threshold. Bit 0 has no effect. A hit raises `cmp_hit_evt_o` and leaves the count at the hit value.
- R8: When several compare modes are enabled, the at-maximum mode takes precedence over the equal mode, and the equal mode over the below-by-one mode. The measurement therefore ends at the earliest of their matches.
- R9: Each strobe lasts one cycle, and at most one strobe is high at a time. After any outcome, the next tick reloads all ones and a new measurement begins. Edges and compares are ignored while the reload is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tach_a_i | input | 1 | Tachometer pin A |
| tach_b_i | input | 1 | Tachometer pin B |
| tach_sel_i | input | 1 | Pin select, 0 = A, 1 = B |
| edge_pol_i | input | 1 | Edge polarity, 1 = rising, 0 = falling |
| prescale_i | input | 8 | Prescale value P, tick every P+1 cycles |
| mode_en_i | input | 1 | Capture mode enable |
| chan_en_i | input | 1 | Channel enable |
| clk_sel_i | input | 1 | Channel clock select |
| cmp_cfg_i | input | 4 | Compare configuration: bit 3 max, bit 2 equal, bit 1 below-by-one |
| cmp_thresh_i | input | 16 | Compare threshold |
| count_o | output | 16 | Live count |
| capture_o | output | 16 | Last captured count |
| capture_evt_o | output | 1 | Capture strobe |
| underflow_evt_o | output | 1 | Underflow strobe |
| cmp_hit_evt_o | output | 1 | Compare hit strobe |

## Verification
The assertions run on every cycle and check that the count only steps down by one or reloads all ones. They also check that strobes are exclusive and one cycle long, that the count freezes at the captured or hit value, that an underflow leaves the capture register alone, and that an idle channel rests at all ones. The directed scenarios cover the rest: pin selection and edge polarity, the three-edge synchronizer latency, the prescaler spacing, each compare mode and their precedence, and a full count down to underflow.

// File: rtl/tach_pkg.sv
package tach_pkg;

    // Bit positions inside the compare configuration field
    localparam int unsigned CMP_HIGH_BIT  = 3;
    localparam int unsigned CMP_EQUAL_BIT = 2;
    localparam int unsigned CMP_LOW_BIT   = 1;

    // Which compare mode matched, already resolved by precedence
    typedef enum logic [1:0] {
        CMP_NONE  = 2'd0,
        CMP_HIGH  = 2'd1,
        CMP_EQUAL = 2'd2,
        CMP_LOW   = 2'd3
    } cmp_kind_e;

endpackage

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [PW-1:0] prescale_i,
    output logic          tick_o
);

    typedef struct packed {
        logic [PW-1:0] pcnt;
    } presc_state_t;

    presc_state_t st_d, st_q;
    logic         tick_w;

    always_comb begin
        tick_w = run_i && (st_q.pcnt >= prescale_i);
        st_d   = st_q;
        if (!run_i) begin
            st_d.pcnt = '0;
        end else if (tick_w) begin
            st_d.pcnt = '0;
        end else begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = tick_w;

endmodule

// File: rtl/tach_edge_detect.sv
module tach_edge_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_a_i,
    input  logic pin_b_i,
    input  logic sel_i,
    input  logic rise_i,
    output logic edge_o
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        pin_w;
    logic        lvl_w;

    assign pin_w = sel_i ? pin_b_i : pin_a_i;
    assign lvl_w = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_w};
        st_d.prev = lvl_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o = rise_i ? (lvl_w & ~st_q.prev) : (~lvl_w & st_q.prev);

endmodule

// File: rtl/tach_cmp_eval.sv
module tach_cmp_eval
    import tach_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] thresh_i,
    input  logic [3:0]   cfg_i,
    output cmp_kind_e    kind_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic      high_w, equal_w, low_w;
    logic      unused_sel;

    assign unused_sel = cfg_i[0];

    assign high_w  = cfg_i[CMP_HIGH_BIT]  && (cnt_i == CNT_MAX);
    assign equal_w = cfg_i[CMP_EQUAL_BIT] && (cnt_i == thresh_i);
    assign low_w   = cfg_i[CMP_LOW_BIT]   && (thresh_i != '0)
                     && (cnt_i == (thresh_i - 1'b1));

    always_comb begin
        if (high_w) begin
            kind_o = CMP_HIGH;
        end else if (equal_w) begin
            kind_o = CMP_EQUAL;
        end else if (low_w) begin
            kind_o = CMP_LOW;
        end else begin
            kind_o = CMP_NONE;
        end
    end

endmodule

// File: rtl/tach_meas_core.sv
module tach_meas_core
    import tach_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         edge_i,
    input  cmp_kind_e    kind_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cap_o,
    output logic         cap_evt_o,
    output logic         unf_evt_o,
    output logic         hit_evt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cap;
        logic         done;
        logic         cap_evt;
        logic         unf_evt;
        logic         hit_evt;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        hit_w;

    assign hit_w = (kind_i != CMP_NONE);

    always_comb begin
        st_d         = st_q;
        st_d.cap_evt = 1'b0;
        st_d.unf_evt = 1'b0;
        st_d.hit_evt = 1'b0;
        if (!run_i) begin
            st_d.cnt  = CNT_MAX;
            st_d.done = 1'b0;
        end else if (st_q.done) begin
            if (tick_i) begin
                st_d.cnt  = CNT_MAX;
                st_d.done = 1'b0;
            end
        end else if (tick_i && hit_w) begin
            st_d.hit_evt = 1'b1;
            st_d.done    = 1'b1;
        end else if (edge_i) begin
            st_d.cap     = st_q.cnt;
            st_d.cap_evt = 1'b1;
            st_d.done    = 1'b1;
        end else if (tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.unf_evt = 1'b1;
                st_d.done    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cap_o     = st_q.cap;
    assign cap_evt_o = st_q.cap_evt;
    assign unf_evt_o = st_q.unf_evt;
    assign hit_evt_o = st_q.hit_evt;

endmodule

// File: rtl/tach_capture_chan.sv
module tach_capture_chan
    import tach_pkg::*;
#(
    parameter int unsigned W  = 16,
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tach_a_i,
    input  logic          tach_b_i,
    input  logic          tach_sel_i,
    input  logic          edge_pol_i,
    input  logic [PW-1:0] prescale_i,
    input  logic          mode_en_i,
    input  logic          chan_en_i,
    input  logic          clk_sel_i,
    input  logic [3:0]    cmp_cfg_i,
    input  logic [W-1:0]  cmp_thresh_i,
    output logic [W-1:0]  count_o,
    output logic [W-1:0]  capture_o,
    output logic          capture_evt_o,
    output logic          underflow_evt_o,
    output logic          cmp_hit_evt_o
);

    logic      run_w;
    logic      tick_w;
    logic      edge_w;
    cmp_kind_e kind_w;

    assign run_w = mode_en_i & chan_en_i & clk_sel_i;

    tach_prescaler #(.PW(PW)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .prescale_i (prescale_i),
        .tick_o     (tick_w)
    );

    tach_edge_detect #(.SYNC_STAGES(2)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_a_i (tach_a_i),
        .pin_b_i (tach_b_i),
        .sel_i   (tach_sel_i),
        .rise_i  (edge_pol_i),
        .edge_o  (edge_w)
    );

    tach_cmp_eval #(.W(W)) u_cmp (
        .cnt_i    (count_o),
        .thresh_i (cmp_thresh_i),
        .cfg_i    (cmp_cfg_i),
        .kind_o   (kind_w)
    );

    tach_meas_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_w),
        .tick_i    (tick_w),
        .edge_i    (edge_w),
        .kind_i    (kind_w),
        .cnt_o     (count_o),
        .cap_o     (capture_o),
        .cap_evt_o (capture_evt_o),
        .unf_evt_o (underflow_evt_o),
        .hit_evt_o (cmp_hit_evt_o)
    );

endmodule

// File: rtl/tach_capture_chan_chk.sv
module tach_capture_chan_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_en_i,
    input logic         chan_en_i,
    input logic         clk_sel_i,
    input logic [W-1:0] count_o,
    input logic [W-1:0] capture_o,
    input logic         capture_evt_o,
    input logic         underflow_evt_o,
    input logic         cmp_hit_evt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic any_evt;
    assign any_evt = capture_evt_o | underflow_evt_o | cmp_hit_evt_o;

    AST_IDLE_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_en_i & chan_en_i & clk_sel_i) |=> (count_o == CNT_MAX) && !any_evt); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |->
            ((count_o == $past(count_o) - 1'b1) || (count_o == CNT_MAX))); // R3

    AST_CAPTURE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        capture_evt_o |-> (capture_o == count_o)); // R5

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_evt_o |-> (count_o == '0) && $stable(capture_o)); // R6

    AST_HIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit_evt_o |-> (count_o == $past(count_o))); // R7

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({capture_evt_o, underflow_evt_o, cmp_hit_evt_o})); // R9

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_evt |=> !any_evt); // R9

endmodule

bind tach_capture_chan tach_capture_chan_chk #(.W(W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_en_i       (mode_en_i),
    .chan_en_i       (chan_en_i),
    .clk_sel_i       (clk_sel_i),
    .count_o         (count_o),
    .capture_o       (capture_o),
    .capture_evt_o   (capture_evt_o),
    .underflow_evt_o (underflow_evt_o),
    .cmp_hit_evt_o   (cmp_hit_evt_o)
);

// File: tb/tach_capture_chan_tb.sv
module tach_capture_chan_tb;

    localparam logic [15:0] MAXV = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tach_a = 1'b0, tach_b = 1'b0, tach_sel = 1'b0, edge_pol = 1'b1;
    logic [7:0]  prescale = 8'd0;
    logic        mode_en = 1'b0, chan_en = 1'b0, clk_sel = 1'b0;
    logic [3:0]  cmp_cfg = 4'd0;
    logic [15:0] cmp_thresh = 16'd0;
    logic [15:0] count_o, capture_o;
    logic        cap_evt, unf_evt, hit_evt;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    tach_capture_chan u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tach_a_i        (tach_a),
        .tach_b_i        (tach_b),
        .tach_sel_i      (tach_sel),
        .edge_pol_i      (edge_pol),
        .prescale_i      (prescale),
        .mode_en_i       (mode_en),
        .chan_en_i       (chan_en),
        .clk_sel_i       (clk_sel),
        .cmp_cfg_i       (cmp_cfg),
        .cmp_thresh_i    (cmp_thresh),
        .count_o         (count_o),
        .capture_o       (capture_o),
        .capture_evt_o   (cap_evt),
        .underflow_evt_o (unf_evt),
        .cmp_hit_evt_o   (hit_evt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_on();
        mode_en = 1'b1; chan_en = 1'b1; clk_sel = 1'b1;
    endtask

    task automatic run_off();
        mode_en = 1'b0;
        wait_n(4);
    endtask

    // counts strobes over n cycles; expects none
    task automatic watch_none(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cap_evt | unf_evt | hit_evt) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic t_reset();
        chk("R1 count after reset", count_o, MAXV);
        chk("R1 capture after reset", capture_o, 0);
        chk("R1 strobes after reset", {cap_evt, unf_evt, hit_evt}, 0);
    endtask

    task automatic t_disabled();
        chan_en = 1'b1; clk_sel = 1'b1; mode_en = 1'b0;
        wait_n(5);
        chk("R2 mode off holds max", count_o, MAXV);
        tach_a = 1'b1;
        watch_none(6, "R2 edge ignored with mode off");
        tach_a = 1'b0;
        wait_n(4);
        mode_en = 1'b1; clk_sel = 1'b0;
        wait_n(5);
        chk("R2 clock select off holds max", count_o, MAXV);
        clk_sel = 1'b0; mode_en = 1'b0;
        wait_n(2);
    endtask

    task automatic t_prescale();
        prescale = 8'd3;
        run_on();
        wait_n(3);
        chk("R3 no decrement before P+1", count_o, MAXV);
        wait_n(1);
        chk("R3 first decrement at P+1", count_o, MAXV - 16'd1);
        wait_n(3);
        chk("R3 held between ticks", count_o, MAXV - 16'd1);
        wait_n(1);
        chk("R3 second decrement", count_o, MAXV - 16'd2);
        run_off();
        prescale = 8'd0;
    endtask

    task automatic t_capture();
        logic [15:0] c;
        edge_pol = 1'b1; tach_sel = 1'b0;
        run_on();
        wait_n(10);
        c = count_o;
        tach_a = 1'b1;
        wait_n(2);
        chk("R5 no strobe before third edge", cap_evt, 0);
        wait_n(1);
        chk("R5 capture strobe", cap_evt, 1);
        chk("R5 captured value", capture_o, c - 16'd2);
        chk("R5 count held at capture", count_o, c - 16'd2);
        wait_n(1);
        chk("R9 strobe one cycle", cap_evt, 0);
        chk("R9 reload after capture", count_o, MAXV);
        tach_a = 1'b0;
        watch_none(6, "R4 falling edge ignored in rising mode");
        run_off();
    endtask

    task automatic t_select();
        logic [15:0] c;
        tach_sel = 1'b1; edge_pol = 1'b0;
        run_on();
        wait_n(4);
        tach_a = 1'b1;
        watch_none(6, "R4 unselected pin ignored");
        tach_b = 1'b1;
        watch_none(6, "R4 rising edge ignored in falling mode");
        c = count_o;
        tach_b = 1'b0;
        wait_n(3);
        chk("R4 falling edge on pin B captures", cap_evt, 1);
        chk("R4 pin B captured value", capture_o, c - 16'd2);
        run_off();
        tach_a = 1'b0; tach_sel = 1'b0; edge_pol = 1'b1;
        wait_n(4);
    endtask

    task automatic t_cmp_high();
        cmp_cfg = 4'b1000; cmp_thresh = 16'd0;
        run_on();
        wait_n(1);
        chk("R7 high hit at start", hit_evt, 1);
        chk("R7 high hit count", count_o, MAXV);
        wait_n(1);
        chk("R9 high hit single cycle", hit_evt, 0);
        wait_n(1);
        chk("R7 high hit repeats after reload", hit_evt, 1);
        run_off();
    endtask

    task automatic t_cmp_eq();
        cmp_cfg = 4'b0100; cmp_thresh = 16'hFFF0;
        run_on();
        wait_n(15);
        chk("R7 equal not yet hit", hit_evt, 0);
        chk("R7 count at threshold", count_o, 16'hFFF0);
        wait_n(1);
        chk("R7 equal hit", hit_evt, 1);
        chk("R7 equal hit holds count", count_o, 16'hFFF0);
        wait_n(1);
        chk("R9 reload after hit", count_o, MAXV);
        run_off();
    endtask

    task automatic t_cmp_low();
        cmp_cfg = 4'b0010; cmp_thresh = 16'hFFF0;
        run_on();
        wait_n(16);
        chk("R7 low not hit at threshold", hit_evt, 0);
        wait_n(1);
        chk("R7 low hit", hit_evt, 1);
        chk("R7 low hit count", count_o, 16'hFFEF);
        run_off();
    endtask

    task automatic t_priority();
        cmp_cfg = 4'b1100; cmp_thresh = 16'hFFF0;
        run_on();
        wait_n(1);
        chk("R8 high precedes equal", hit_evt, 1);
        chk("R8 high hit value", count_o, MAXV);
        run_off();
        cmp_cfg = 4'b0110;
        run_on();
        wait_n(16);
        chk("R8 equal precedes low", hit_evt, 1);
        chk("R8 equal hit value", count_o, 16'hFFF0);
        run_off();
    endtask

    task automatic t_underflow();
        logic [15:0] p;
        int seen = 0;
        cmp_cfg = 4'b0011; cmp_thresh = 16'd0;
        p = capture_o;
        run_on();
        for (int i = 0; i < 65535; i++) begin
            @(negedge clk);
            if (cap_evt | unf_evt | hit_evt) seen++;
        end
        chk("R7 low with zero threshold and bit0 inert", seen, 0);
        chk("R6 count reaches zero", count_o, 0);
        wait_n(1);
        chk("R6 underflow strobe", unf_evt, 1);
        chk("R6 count stays zero", count_o, 0);
        chk("R6 capture unchanged", capture_o, p);
        wait_n(1);
        chk("R9 reload after underflow", count_o, MAXV);
        chk("R9 underflow single cycle", unf_evt, 0);
        run_off();
        cmp_cfg = 4'd0;
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_disabled();
        t_prescale();
        t_capture();
        t_select();
        t_cmp_high();
        t_cmp_eq();
        t_cmp_low();
        t_priority();
        t_underflow();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule